// File: doc/BRIEF.md
# Two-Level Peripheral Interrupt Aggregator

This block gathers single-cycle event strobes from a handful of peripherals and folds them into interrupt requests for a small microcontroller core. Four peripheral events (two timer overflows, a waveform-generator event and a compare-channel-5 event) are first latched in an 8-bit peripheral pending register. A peripheral mask register decides which of them travel up into two summary bits of a 16-bit main pending vector. One summary bit stands for the peripheral group (waveform generator and compare 5). The other stands for timer overflow (either timer). The main vector also takes six direct event strobes. A main mask register selects which main pending bits drive the single CPU request line.

Software reaches the registers through a plain register port. It has an address, a write strobe with data, and a read strobe whose data appears one cycle later. Reading the peripheral pending register clears it, so software keeps a copy of the value it read. A main pending bit is cleared by a register write or by a per-bit acknowledge pulse from the interrupt controller.

Top module: `pirq_agg`

## Requirements
- R1: After reset every pending and mask bit is 0, `cpu_irq` is low and `reg_rdata` is 0.
- R2: A strobe on `evt_tmr1_ovf`, `evt_tmr2_ovf`, `evt_wavegen` or `evt_cmp5` sets bit 0, 2, 4 or 6 of the peripheral pending register (address 0) on the next clock, whatever the peripheral mask holds.
- R3: A read (`reg_rd`) puts the addressed register on `reg_rdata` one cycle later. A read of address 0 returns the value held before the read and clears the whole peripheral pending register. An event strobe in the same cycle as that read is still set afterwards.
- R4: Bits 1, 3, 5 and 7 of the peripheral pending register (address 0) and the peripheral mask register (address 1) always read as 1, and writes to them are ignored. Address 0 cannot be written at all.
- R5: The peripheral-group summary (main index 13, bit 5 of address 4) is set on the clock after a waveform-generator or compare-5 strobe whose peripheral mask bit (4 or 6) is 1. A strobe whose mask bit is 0 leaves it unchanged.
- R6: The timer-overflow summary (main index 0, bit 0 of address 2) is set on the clock after a timer 1 or timer 2 strobe whose peripheral mask bit (0 or 2) is 1. A strobe whose mask bit is 0 leaves it unchanged.
- R7: Direct strobes `evt_direct[4:0]` set main indices 8 to 12 (bits 0 to 4 of address 4), and `evt_direct[5]` sets index 14 (bit 6 of address 4). The reserved main bits (address 2 bits 7:1 and address 4 bit 7) read 0 and cannot be set.
- R8: `cpu_irq` is high exactly while some main pending bit and the same main mask bit are both 1. The main mask is at address 3 for indices 7:0 and at address 5 for indices 15:8.
- R9: A write to address 2 or 4 loads the written byte into the main pending bits it covers: 0 clears a bit and 1 sets it. `irq_ack[i]` clears main index i. A set event in the same cycle wins over the write or the acknowledge.
- R10: Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| evt_tmr1_ovf | input | 1 | Timer 1 overflow strobe |
| evt_tmr2_ovf | input | 1 | Timer 2 overflow strobe |
| evt_wavegen | input | 1 | Waveform-generator event strobe |
| evt_cmp5 | input | 1 | Compare channel 5 event strobe |
| evt_direct | input | 6 | Direct main-level event strobes |
| irq_ack | input | 16 | Per-index acknowledge pulses for the main pending vector |
| cpu_irq | output | 1 | CPU interrupt request |

## Verification
The assertions take for granted that `reg_rd` and `reg_wr` are never high in the same cycle. They also assume that every strobe, whether an event or an acknowledge, lasts exactly one cycle. The stimulus follows this: every task drives a port operation or a strobe for a single cycle at the falling edge and then returns it to zero. The only deliberate overlap is an event strobe in the same cycle as a read or an acknowledge, and the assertions are written to allow it. The peripheral pending register is read after every test, so no event is left over into the next scenario.

// File: rtl/pirq_agg_pkg.sv
package pirq_agg_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int N_PERIPH = 4;
    localparam int MAIN_W   = 2 * DATA_W;
    localparam int N_DIRECT = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_SUB_PEND = 3'd0,
        A_SUB_MASK = 3'd1,
        A_MLO_PEND = 3'd2,
        A_MLO_MASK = 3'd3,
        A_MHI_PEND = 3'd4,
        A_MHI_MASK = 3'd5,
        A_SPARE6   = 3'd6,
        A_SPARE7   = 3'd7
    } reg_addr_e;

    // peripheral pending bit positions (event k lands at bit 2k)
    localparam int SB_T1 = 0;
    localparam int SB_T2 = 2;
    localparam int SB_WG = 4;
    localparam int SB_C5 = 6;
    localparam logic [DATA_W-1:0] SUB_IMPL = 8'h55;

    // main pending vector indices
    localparam int MI_TOVF = 0;
    localparam int MI_GRP  = 13;
    localparam int MI_EXT  = 14;
    localparam logic [MAIN_W-1:0] MAIN_IMPL = 16'h7F01;

    typedef struct packed {
        logic [DATA_W-1:0] pend;
        logic [DATA_W-1:0] mask;
    } sub_state_t;

    typedef struct packed {
        logic [MAIN_W-1:0] pend;
        logic [MAIN_W-1:0] mask;
    } main_state_t;

endpackage

// File: rtl/pirq_sub_stage.sv
module pirq_sub_stage
    import pirq_agg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PERIPH-1:0] evt,
    input  logic                wr_mask,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                rd_clr,
    output logic [DATA_W-1:0]   pend_q,
    output logic [DATA_W-1:0]   mask_q,
    output logic                grp_set,
    output logic                tovf_set
);

    sub_state_t        st_d, st_q;
    logic [DATA_W-1:0] evt_vec;

    // spread the event strobes onto the even bit positions
    generate
        for (genvar k = 0; k < DATA_W; k++) begin : g_spread
            if ((k % 2) == 0 && (k / 2) < N_PERIPH) begin : g_evt
                assign evt_vec[k] = evt[k/2];
            end else begin : g_rsv
                assign evt_vec[k] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.pend = (rd_clr ? '0 : st_q.pend) | evt_vec;
        if (wr_mask) begin
            st_d.mask = wdata & SUB_IMPL;
        end
        grp_set  = (evt_vec[SB_WG] & st_q.mask[SB_WG]) |
                   (evt_vec[SB_C5] & st_q.mask[SB_C5]);
        tovf_set = (evt_vec[SB_T1] & st_q.mask[SB_T1]) |
                   (evt_vec[SB_T2] & st_q.mask[SB_T2]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;
    assign mask_q = st_q.mask;

    AST_SUB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((pend_q & $past(evt_vec)) == $past(evt_vec))); // R2

    AST_SUB_RDCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && evt == '0) |=> (pend_q == '0)); // R3

    AST_SUB_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask_q)); // R4

endmodule

// File: rtl/pirq_main_stage.sv
module pirq_main_stage
    import pirq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAIN_W-1:0] set_vec,
    input  logic [MAIN_W-1:0] ack,
    input  logic              wr_pend_lo,
    input  logic              wr_pend_hi,
    input  logic              wr_mask_lo,
    input  logic              wr_mask_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [MAIN_W-1:0] pend_q,
    output logic [MAIN_W-1:0] mask_q,
    output logic              irq
);

    main_state_t       st_d, st_q;
    logic [MAIN_W-1:0] kept;

    always_comb begin
        st_d = st_q;
        kept = st_q.pend;
        if (wr_pend_lo) kept[DATA_W-1:0]      = wdata;
        if (wr_pend_hi) kept[MAIN_W-1:DATA_W] = wdata;
        kept      = kept & ~ack;
        st_d.pend = (kept | set_vec) & MAIN_IMPL;
        if (wr_mask_lo) st_d.mask[DATA_W-1:0]      = wdata;
        if (wr_mask_hi) st_d.mask[MAIN_W-1:DATA_W] = wdata;
        st_d.mask = st_d.mask & MAIN_IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;
    assign mask_q = st_q.mask;
    assign irq    = |(st_q.pend & st_q.mask);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec))); // R9

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack != '0 && set_vec == '0 && !wr_pend_lo && !wr_pend_hi)
        |=> ((pend_q & $past(ack)) == '0)); // R9

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && set_vec == '0 && !wr_pend_lo && !wr_pend_hi &&
         !wr_mask_lo && !wr_mask_hi) |=> !irq); // R8

endmodule

// File: rtl/pirq_rd_mux.sv
module pirq_rd_mux
    import pirq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] sub_pend,
    input  logic [DATA_W-1:0] sub_mask,
    input  logic [MAIN_W-1:0] main_pend,
    input  logic [MAIN_W-1:0] main_mask,
    output logic [DATA_W-1:0] rdata_q
);

    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W-1:0] sel;

    always_comb begin
        case (reg_addr_e'(addr))
            A_SUB_PEND: sel = sub_pend | ~SUB_IMPL;
            A_SUB_MASK: sel = sub_mask | ~SUB_IMPL;
            A_MLO_PEND: sel = main_pend[DATA_W-1:0];
            A_MLO_MASK: sel = main_mask[DATA_W-1:0];
            A_MHI_PEND: sel = main_pend[MAIN_W-1:DATA_W];
            A_MHI_MASK: sel = main_mask[MAIN_W-1:DATA_W];
            default:    sel = '0;
        endcase
        rdata_d = rd_en ? sel : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    AST_SUB_RSV_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr <= 3'd1) |=> ((rdata_q & ~SUB_IMPL) == ~SUB_IMPL)); // R4

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr >= 3'd6) |=> (rdata_q == '0)); // R10

endmodule

// File: rtl/pirq_agg.sv
module pirq_agg
    import pirq_agg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                reg_rd,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                evt_tmr1_ovf,
    input  logic                evt_tmr2_ovf,
    input  logic                evt_wavegen,
    input  logic                evt_cmp5,
    input  logic [N_DIRECT-1:0] evt_direct,
    input  logic [MAIN_W-1:0]   irq_ack,
    output logic                cpu_irq
);

    logic [DATA_W-1:0] sub_pend, sub_mask;
    logic [MAIN_W-1:0] main_pend, main_mask, set_vec;
    logic              grp_set, tovf_set;
    logic              sub_rd_clr, wr_sub_mask;
    logic              wr_mlo_p, wr_mhi_p, wr_mlo_m, wr_mhi_m;

    always_comb begin
        sub_rd_clr  = reg_rd && (reg_addr == A_SUB_PEND);
        wr_sub_mask = reg_wr && (reg_addr == A_SUB_MASK);
        wr_mlo_p    = reg_wr && (reg_addr == A_MLO_PEND);
        wr_mlo_m    = reg_wr && (reg_addr == A_MLO_MASK);
        wr_mhi_p    = reg_wr && (reg_addr == A_MHI_PEND);
        wr_mhi_m    = reg_wr && (reg_addr == A_MHI_MASK);
    end

    // main-level set sources: summaries and direct strobes
    always_comb begin
        set_vec          = '0;
        set_vec[MI_TOVF] = tovf_set;
        set_vec[MI_GRP]  = grp_set;
        set_vec[MI_EXT]  = evt_direct[N_DIRECT-1];
        for (int k = 0; k < N_DIRECT - 1; k++) begin
            set_vec[DATA_W + k] = evt_direct[k];
        end
    end

    pirq_sub_stage u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      ({evt_cmp5, evt_wavegen, evt_tmr2_ovf, evt_tmr1_ovf}),
        .wr_mask  (wr_sub_mask),
        .wdata    (reg_wdata),
        .rd_clr   (sub_rd_clr),
        .pend_q   (sub_pend),
        .mask_q   (sub_mask),
        .grp_set  (grp_set),
        .tovf_set (tovf_set)
    );

    pirq_main_stage u_main (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .ack        (irq_ack),
        .wr_pend_lo (wr_mlo_p),
        .wr_pend_hi (wr_mhi_p),
        .wr_mask_lo (wr_mlo_m),
        .wr_mask_hi (wr_mhi_m),
        .wdata      (reg_wdata),
        .pend_q     (main_pend),
        .mask_q     (main_mask),
        .irq        (cpu_irq)
    );

    pirq_rd_mux u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (reg_rd),
        .addr      (reg_addr),
        .sub_pend  (sub_pend),
        .sub_mask  (sub_mask),
        .main_pend (main_pend),
        .main_mask (main_mask),
        .rdata_q   (reg_rdata)
    );

    AST_GRP_NEEDS_SUBMASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_pend[MI_GRP] && !wr_mhi_p &&
         !((evt_wavegen && sub_mask[SB_WG]) || (evt_cmp5 && sub_mask[SB_C5])))
        |=> !main_pend[MI_GRP]); // R5

    AST_TOVF_NEEDS_SUBMASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_pend[MI_TOVF] && !wr_mlo_p &&
         !((evt_tmr1_ovf && sub_mask[SB_T1]) || (evt_tmr2_ovf && sub_mask[SB_T2])))
        |=> !main_pend[MI_TOVF]); // R6

endmodule

// File: tb/pirq_agg_tb.sv
module pirq_agg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic        evt_tmr1_ovf = 1'b0, evt_tmr2_ovf = 1'b0;
    logic        evt_wavegen = 1'b0, evt_cmp5 = 1'b0;
    logic [5:0]  evt_direct = '0;
    logic [15:0] irq_ack = '0;
    logic        cpu_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pirq_agg u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .evt_tmr1_ovf(evt_tmr1_ovf), .evt_tmr2_ovf(evt_tmr2_ovf),
        .evt_wavegen(evt_wavegen), .evt_cmp5(evt_cmp5),
        .evt_direct(evt_direct), .irq_ack(irq_ack), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    // one-cycle strobe of peripheral events {c5,wg,t2,t1}, direct events and acks
    task automatic pulse(input logic [3:0] pe, input logic [5:0] de, input logic [15:0] ak);
        @(negedge clk);
        {evt_cmp5, evt_wavegen, evt_tmr2_ovf, evt_tmr1_ovf} = pe;
        evt_direct = de; irq_ack = ak;
        @(negedge clk);
        {evt_cmp5, evt_wavegen, evt_tmr2_ovf, evt_tmr1_ovf} = '0;
        evt_direct = '0; irq_ack = '0;
    endtask

    task automatic cleanup();
        logic [7:0] d;
        wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd5, 8'h00);
        wr(3'd2, 8'h00); wr(3'd4, 8'h00);
        rd(3'd0, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 irq after reset", 16'(cpu_irq), 16'h0);
        chk("R1 rdata after reset", 16'(reg_rdata), 16'h0);
        rd(3'd0, d); chk("R1/R4 sub pend reset", 16'(d), 16'h00AA);
        rd(3'd1, d); chk("R1/R4 sub mask reset", 16'(d), 16'h00AA);
        rd(3'd2, d); chk("R1 main lo pend", 16'(d), 16'h0);
        rd(3'd4, d); chk("R1 main hi pend", 16'(d), 16'h0);
        rd(3'd5, d); chk("R1 main hi mask", 16'(d), 16'h0);
    endtask

    task automatic t_capture();
        logic [7:0] d;
        pulse(4'b0001, '0, '0);
        pulse(4'b1110, '0, '0);
        rd(3'd0, d); chk("R2 all events recorded unmasked", 16'(d), 16'h00FF);
        rd(3'd0, d); chk("R3 read cleared sub pend", 16'(d), 16'h00AA);
        rd(3'd2, d); chk("R6 no tovf summary when unmasked", 16'(d), 16'h0);
        rd(3'd4, d); chk("R5 no group summary when unmasked", 16'(d), 16'h0);
    endtask

    task automatic t_read_race();
        logic [7:0] d;
        @(negedge clk);
        reg_addr = 3'd0; reg_rd = 1'b1; evt_wavegen = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; evt_wavegen = 1'b0;
        chk("R3 read returns pre-event value", 16'(reg_rdata), 16'h00AA);
        rd(3'd0, d); chk("R3 event survives same-cycle read", 16'(d), 16'h00BA);
    endtask

    task automatic t_rsv_write();
        logic [7:0] d;
        wr(3'd1, 8'hAA);
        rd(3'd1, d); chk("R4 reserved mask bits ignore writes", 16'(d), 16'h00AA);
        wr(3'd0, 8'h55);
        rd(3'd0, d); chk("R4 sub pend not writable", 16'(d), 16'h00AA);
        wr(3'd6, 8'hFF);
        rd(3'd6, d); chk("R10 spare address reads 0", 16'(d), 16'h0);
        rd(3'd3, d); chk("R10 spare write left masks", 16'(d), 16'h0);
    endtask

    task automatic t_group();
        logic [7:0] d;
        wr(3'd5, 8'h20); wr(3'd1, 8'h10);
        pulse(4'b1000, '0, '0);
        chk("R5 masked-off cmp5 gives no irq", 16'(cpu_irq), 16'h0);
        rd(3'd4, d); chk("R5 cmp5 masked: no group bit", 16'(d), 16'h0);
        pulse(4'b0100, '0, '0);
        chk("R8 group summary raises irq", 16'(cpu_irq), 16'h1);
        rd(3'd4, d); chk("R5 group bit set by wavegen", 16'(d), 16'h0020);
        wr(3'd4, 8'h00);
        chk("R9 write 0 clears group bit", 16'(cpu_irq), 16'h0);
        cleanup();
    endtask

    task automatic t_tovf();
        logic [7:0] d;
        wr(3'd3, 8'h01); wr(3'd1, 8'h04);
        pulse(4'b0001, '0, '0);
        rd(3'd2, d); chk("R6 timer1 masked off", 16'(d), 16'h0);
        pulse(4'b0010, '0, '0);
        chk("R8 tovf summary raises irq", 16'(cpu_irq), 16'h1);
        rd(3'd2, d); chk("R6 timer2 sets tovf", 16'(d), 16'h0001);
        pulse('0, '0, 16'h0001);
        chk("R9 ack clears tovf", 16'(cpu_irq), 16'h0);
        wr(3'd3, 8'h00);
        pulse(4'b0010, '0, '0);
        chk("R8 main mask blocks irq", 16'(cpu_irq), 16'h0);
        wr(3'd3, 8'h01);
        chk("R8 enabling main mask raises irq", 16'(cpu_irq), 16'h1);
        cleanup();
    endtask

    task automatic t_direct();
        logic [7:0] d;
        pulse('0, 6'h3F, '0);
        rd(3'd4, d); chk("R7 direct events map", 16'(d), 16'h005F);
        wr(3'd4, 8'hFF);
        rd(3'd4, d); chk("R7/R9 write sets, reserved stays 0", 16'(d), 16'h007F);
        wr(3'd2, 8'hFF);
        rd(3'd2, d); chk("R7 lo reserved bits stay 0", 16'(d), 16'h0001);
        wr(3'd5, 8'h40);
        chk("R8 ext bit raises irq", 16'(cpu_irq), 16'h1);
        pulse('0, 6'h20, 16'h4000);
        rd(3'd4, d); chk("R9 set wins over ack", 16'(d), 16'h007F);
        pulse('0, '0, 16'h4000);
        rd(3'd4, d); chk("R9 ack clears ext", 16'(d), 16'h003F);
        chk("R8 irq drops with ext cleared", 16'(cpu_irq), 16'h0);
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture();
        t_read_race();
        t_rsv_write();
        t_group();
        t_tovf();
        t_direct();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule